// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a successive approximation analog-to-digital converter. It drives the code register of an external DAC and reads one bit from an external comparator. The comparator bit is high when the sampled input is at or above the level the DAC currently produces. A start pulse latches the configuration and runs a sample phase of programmable length. The block then resolves the result one bit per conversion clock, from the most significant bit down. When the last bit is settled, a one-cycle done pulse appears together with the result.

The result is ratiometric. Code 0 stands for the low reference and the all-ones code 0x3FF stands for the high reference. A mode bit selects a full 10-bit conversion or a short 8-bit conversion. In the short mode only the upper eight bits are resolved.

The conversion clock is not a separate clock. It is a tick derived from the bus clock. A 5-bit value N divides the bus clock by N+1, and that rate is halved again. System software must pick N so that the conversion rate stays between 500 kHz and 2 MHz. The controller itself does not check this. An abort input cancels any conversion at once. A new start pulse during a conversion restarts it from the sample phase.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `dac_code` and `result` are all zero.
- R2: In 10-bit mode (`short_mode`=0), the final `result` is the largest 10-bit code whose DAC level the input reaches. Each trial sets the bit under test and keeps it only when `cmp_hi` is 1, so an ideal comparator yields the input code itself.
- R3: In 8-bit mode (`short_mode`=1), only bits 9 down to 2 are tried, and `result[1:0]` reads as zero.
- R4: The sample phase lasts 2, 4, 8 or 16 conversion clocks for `smp_sel` codes 00, 01, 10 and 11. `done` rises exactly 2·(N+1)·(S+B) bus clock edges after the edge that samples `start`, where S is the sample length and B is 10 or 8.
- R5: The conversion clock period is 2·(N+1) bus clocks, where N is `pre_div`. No two consecutive bus cycles carry a conversion tick.
- R6: The first trial code after the sample phase is 0x200 (MSB only). One conversion clock later, bit 9 holds the comparator decision and bit 8 is set.
- R7: `done` is high for exactly one bus cycle. `busy` is low in that same cycle, and `result` holds its value until the next conversion completes.
- R8: When `abort` is high, the next cycle shows `busy`=0. No `done` follows for that conversion, and `result` keeps its previous value. Abort wins over a simultaneous start.
- R9: A `start` pulse while busy restarts the conversion, and all timing counts from the new start.
- R10: `short_mode`, `smp_sel` and `pre_div` are captured on start. Changing them during a conversion changes neither its timing nor its result.
- R11: The ratiometric end points hold: an input of 0x3FF gives a result of 0x3FF, and an input of 0 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin (or restart) a conversion |
| abort | input | 1 | Cancel the conversion and return to idle |
| short_mode | input | 1 | 1 = 8-bit conversion, 0 = 10-bit conversion |
| smp_sel | input | 2 | Sample length code: 00=2, 01=4, 10=8, 11=16 conversion clocks |
| pre_div | input | 5 | Prescale value N; conversion clock = bus / (2·(N+1)) |
| cmp_hi | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| dac_code | output | 10 | Trial code driven to the DAC |
| result | output | 10 | Last completed conversion code |
| done | output | 1 | One-cycle pulse: `result` has just been updated |
| busy | output | 1 | Conversion in progress (sample or trial phase) |

## Verification
A miscounted prescaler or sample counter shows up as a shift in the edge count between the start edge and the `done` edge. The bench compares that count exactly, so one lost tick moves `done` by a whole conversion period. A wrong bit index or a wrong keep/clear decision shows on `dac_code` within one conversion clock of the trial. It also corrupts the final `result`, which is checked against the bench's own input code at `done`. A sequencer that does not return to idle on abort shows as `busy` still high one cycle later, or as a stray `done` pulse during the following watch window.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int CODE_W  = 10;
    localparam int SHORT_W = 8;
    localparam int PRE_W   = 5;
    localparam int SMP_W   = 2;
    localparam int IDX_W   = $clog2(CODE_W);
    localparam int SCNT_W  = 5;
    localparam logic [IDX_W-1:0] MSB_IDX   = IDX_W'(CODE_W - 1);
    localparam logic [IDX_W-1:0] SHORT_LSB = IDX_W'(CODE_W - SHORT_W);

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_TRIAL  = 2'd2
    } phase_t;

    typedef struct packed {
        logic             short_mode;
        logic [SMP_W-1:0] smp_sel;
        logic [PRE_W-1:0] pre_div;
    } conv_cfg_t;

    // Sample phase length in conversion clocks: 2, 4, 8, 16
    function automatic logic [SCNT_W-1:0] sample_ticks(input logic [SMP_W-1:0] code);
        return SCNT_W'(2) << code;
    endfunction
endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler
    import sar_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] cnt;
    logic             half;
    logic             wrap;

    assign wrap = (cnt == div);
    assign tick = wrap && half;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt  <= '0;
            half <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            half <= ~half;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    // R5
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst) tick |=> !tick)
        else $error("conversion tick on consecutive cycles");
    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst) (!clear && wrap) |=> (cnt == '0))
        else $error("prescale counter did not wrap");
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  conv_cfg_t        cfg_in,
    input  logic             tick,
    output conv_cfg_t        cfg,
    output logic             load_msb,
    output logic             trial_step,
    output logic             trial_final,
    output logic [IDX_W-1:0] trial_idx,
    output logic             busy,
    output logic             done
);
    phase_t            phase;
    logic [SCNT_W-1:0] smp_cnt;
    logic [SCNT_W-1:0] smp_last;
    logic [IDX_W-1:0]  lsb_idx;

    assign smp_last    = sample_ticks(cfg.smp_sel) - SCNT_W'(1);
    assign lsb_idx     = cfg.short_mode ? SHORT_LSB : '0;
    assign load_msb    = (phase == PH_SAMPLE) && tick && (smp_cnt == smp_last);
    assign trial_step  = (phase == PH_TRIAL) && tick;
    assign trial_final = (trial_idx == lsb_idx);
    assign busy        = (phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cfg       <= '0;
            smp_cnt   <= '0;
            trial_idx <= MSB_IDX;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                phase <= PH_IDLE;
            end else if (start) begin
                phase     <= PH_SAMPLE;
                cfg       <= cfg_in;
                smp_cnt   <= '0;
                trial_idx <= MSB_IDX;
            end else begin
                case (phase)
                    PH_SAMPLE: if (tick) begin
                        if (load_msb) begin
                            phase     <= PH_TRIAL;
                            trial_idx <= MSB_IDX;
                        end else begin
                            smp_cnt <= smp_cnt + 1'b1;
                        end
                    end
                    PH_TRIAL: if (tick) begin
                        if (trial_final) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end else begin
                            trial_idx <= trial_idx - 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done)
        else $error("done held longer than one cycle");
    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy)
        else $error("busy still high with done");
    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst) abort |=> (!busy && !done))
        else $error("abort did not return to idle");
    // R4
    smp_bound_chk: assert property (@(posedge clk) disable iff (rst) (phase == PH_SAMPLE) |-> (smp_cnt <= smp_last))
        else $error("sample counter past its length");
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg
    import sar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load_msb,
    input  logic              trial_step,
    input  logic              trial_final,
    input  logic [IDX_W-1:0]  trial_idx,
    input  logic              cmp_hi,
    input  logic              short_mode,
    output logic [CODE_W-1:0] dac_code,
    output logic [CODE_W-1:0] result
);
    localparam logic [CODE_W-1:0] MSB_ONE = CODE_W'(1) << MSB_IDX;

    logic [CODE_W-1:0] next_code;
    logic [IDX_W-1:0]  idx_dn;

    assign idx_dn = trial_idx - IDX_W'(1);

    always_comb begin
        next_code            = dac_code;
        next_code[trial_idx] = cmp_hi;
        if (!trial_final && (trial_idx != '0))
            next_code[idx_dn] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_code <= '0;
            result   <= '0;
        end else if (clear) begin
            dac_code <= '0;
        end else if (load_msb) begin
            dac_code <= MSB_ONE;
        end else if (trial_step) begin
            dac_code <= next_code;
            if (trial_final)
                result <= next_code;
        end
    end

    // R6
    first_trial_chk: assert property (@(posedge clk) disable iff (rst) (load_msb && !clear) |=> (dac_code == MSB_ONE))
        else $error("first trial code is not the MSB alone");
    // R3
    short_low_chk: assert property (@(posedge clk) disable iff (rst)
        (trial_step && trial_final && short_mode && !clear) |=> (result[1:0] == 2'b00))
        else $error("8-bit result has nonzero low bits");
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic              short_mode,
    input  logic [SMP_W-1:0]  smp_sel,
    input  logic [PRE_W-1:0]  pre_div,
    input  logic              cmp_hi,
    output logic [CODE_W-1:0] dac_code,
    output logic [CODE_W-1:0] result,
    output logic              done,
    output logic              busy
);
    conv_cfg_t        cfg_in;
    conv_cfg_t        cfg;
    logic             tick;
    logic             load_msb;
    logic             trial_step;
    logic             trial_final;
    logic [IDX_W-1:0] trial_idx;
    logic             clear_dp;

    assign cfg_in   = '{short_mode: short_mode, smp_sel: smp_sel, pre_div: pre_div};
    assign clear_dp = start || abort;

    sar_prescaler u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (start && !abort),
        .div   (cfg.pre_div),
        .tick  (tick)
    );

    sar_sequencer u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .abort       (abort),
        .cfg_in      (cfg_in),
        .tick        (tick),
        .cfg         (cfg),
        .load_msb    (load_msb),
        .trial_step  (trial_step),
        .trial_final (trial_final),
        .trial_idx   (trial_idx),
        .busy        (busy),
        .done        (done)
    );

    sar_approx_reg u_reg (
        .clk         (clk),
        .rst         (rst),
        .clear       (clear_dp),
        .load_msb    (load_msb),
        .trial_step  (trial_step),
        .trial_final (trial_final),
        .trial_idx   (trial_idx),
        .cmp_hi      (cmp_hi),
        .short_mode  (cfg.short_mode),
        .dac_code    (dac_code),
        .result      (result)
    );
endmodule

// File: tb/tb_sar_conv_ctrl.sv
module tb_sar_conv_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       abort = 1'b0;
    logic       short_mode = 1'b0;
    logic [1:0] smp_sel = 2'b00;
    logic [4:0] pre_div = 5'd0;
    logic [9:0] vin = 10'd0;
    logic       cmp_hi;
    logic [9:0] dac_code;
    logic [9:0] result;
    logic       done;
    logic       busy;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    // ideal comparator model
    assign cmp_hi = (vin >= dac_code);

    sar_conv_ctrl dut (
        .clk(clk), .rst(rst), .start(start), .abort(abort),
        .short_mode(short_mode), .smp_sel(smp_sel), .pre_div(pre_div),
        .cmp_hi(cmp_hi), .dac_code(dac_code), .result(result),
        .done(done), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
    endtask

    // count edges after the start edge until done is seen
    task automatic wait_done(output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!done && n < 5000);
    endtask

    task automatic run_conv(input logic [9:0] v, input bit s8, input logic [1:0] smp,
                            input logic [4:0] pre, input string tag);
        int n;
        int exp_n;
        int b;
        logic [9:0] exp_r;
        b = s8 ? 8 : 10;
        exp_n = 2 * (pre + 1) * ((2 << smp) + b);
        exp_r = s8 ? (v & 10'h3FC) : v;
        @(negedge clk);
        vin = v; short_mode = s8; smp_sel = smp; pre_div = pre;
        pulse_start();
        wait_done(n);
        chk(n == exp_n, {tag, " R4 R5 done timing"}, n, exp_n);
        chk(result == exp_r, {tag, " R2 R3 result"}, result, exp_r);
        chk(!busy, {tag, " R7 busy low with done"}, busy, 0);
        @(posedge clk); @(negedge clk);
        chk(!done, {tag, " R7 done one cycle"}, done, 0);
        chk(result == exp_r, {tag, " R7 result held"}, result, exp_r);
    endtask

    task automatic t_reset();
        chk(!busy && !done, "R1 reset busy/done", {busy, done}, 0);
        chk(dac_code == 0, "R1 reset dac_code", dac_code, 0);
        chk(result == 0, "R1 reset result", result, 0);
    endtask

    task automatic t_trial_order();
        int n;
        @(negedge clk);
        vin = 10'h155; short_mode = 1'b0; smp_sel = 2'b00; pre_div = 5'd0;
        pulse_start();
        repeat (4) begin @(posedge clk); @(negedge clk); end
        chk(dac_code == 10'h200, "R6 first trial code", dac_code, 10'h200);
        repeat (2) begin @(posedge clk); @(negedge clk); end
        chk(dac_code == 10'h100, "R6 second trial code", dac_code, 10'h100);
        wait_done(n);
        chk(result == 10'h155, "R2 trial-order result", result, 10'h155);
    endtask

    task automatic t_abort();
        logic [9:0] prev;
        bit seen;
        prev = result;
        @(negedge clk);
        vin = 10'h123; smp_sel = 2'b01; pre_div = 5'd1;
        pulse_start();
        repeat (10) begin @(posedge clk); @(negedge clk); end
        chk(busy, "R8 busy before abort", busy, 1);
        abort = 1'b1;
        @(posedge clk); @(negedge clk);
        abort = 1'b0;
        chk(!busy, "R8 idle after abort", busy, 0);
        seen = 0;
        repeat (200) begin
            @(posedge clk); @(negedge clk);
            if (done || busy) seen = 1;
        end
        chk(!seen, "R8 no done after abort", seen, 0);
        chk(result == prev, "R8 result kept", result, prev);
        // abort wins over simultaneous start
        @(negedge clk) begin start = 1'b1; abort = 1'b1; end
        @(posedge clk);
        @(negedge clk) begin start = 1'b0; abort = 1'b0; end
        chk(!busy, "R8 abort beats start", busy, 0);
    endtask

    task automatic t_restart();
        int n;
        @(negedge clk);
        vin = 10'h0F0; short_mode = 1'b0; smp_sel = 2'b00; pre_div = 5'd0;
        pulse_start();
        repeat (6) begin @(posedge clk); @(negedge clk); end
        vin = 10'h31A;
        pulse_start();
        wait_done(n);
        chk(n == 24, "R9 restart timing", n, 24);
        chk(result == 10'h31A, "R9 restart result", result, 10'h31A);
    endtask

    task automatic t_cfg_latch();
        int n;
        @(negedge clk);
        vin = 10'h2B7; short_mode = 1'b0; smp_sel = 2'b00; pre_div = 5'd0;
        pulse_start();
        short_mode = 1'b1; smp_sel = 2'b11; pre_div = 5'd5;
        wait_done(n);
        chk(n == 24, "R10 latched timing", n, 24);
        chk(result == 10'h2B7, "R10 latched width", result, 10'h2B7);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        run_conv(10'h2A5, 1'b0, 2'b00, 5'd0,  "10b");
        run_conv(10'h2A7, 1'b1, 2'b01, 5'd1,  "8b");
        run_conv(10'h3FF, 1'b0, 2'b10, 5'd3,  "R11 full");
        run_conv(10'h000, 1'b0, 2'b11, 5'd31, "R11 zero");
        run_conv(10'h3FF, 1'b1, 2'b11, 5'd2,  "8b full");
        t_trial_order();
        t_abort();
        t_restart();
        t_cfg_latch();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule